// File: doc/BRIEF.md
# World-ID Slot Permission Checker

This block guards one protected memory region. Every request that reaches the region carries a byte address, the world ID (WID) of its initiator and a read/write flag. The checker answers allow or deny one cycle later. The answer comes from a small table of rule slots. Each slot holds a word address, a 64-bit permission word and a 2-bit match mode. A slot in top-of-range mode covers the span from the previous slot's address up to its own address. Its permission word carries a read bit and a write bit for each of 32 worlds.

Configuration software reaches the table through a flat register port. Writes are whole 64-bit words and reads are combinational. The last slot has a fixed upper bound at the end of the protected region. Out of reset it grants the trusted world full access, so boot code can run before any rule exists. The first denied request is recorded in an error-cause register and an error-address register. Software releases them by writing zero.

Top module: `wid_slot_checker`

## Requirements
- R1: After reset the count register at offset 0x008 reads NUM_SLOTS (4). Writable slots 0..NUM_SLOTS-1 read address 0, permission 0 and mode 0. The last slot (index NUM_SLOTS) reads mode 1 and a permission word with bits 2*TRUSTED_WID and 2*TRUSTED_WID+1 set. The error-cause register reads 0.
- R2: Slot k occupies offset 0x20+0x20*k. Its word address is at +0x00, its permission word at +0x08 and its 2-bit mode at +0x10. The error cause is at 0x010 and the error address is at 0x018.
- R3: A slot address holds the byte address shifted right by 2. On a write, the low GRAN_BITS-2 bits (10 for the 4 KiB default) are forced to zero, and a read returns the stored value.
- R4: The last slot's address reads REGION_TOP>>2, and writes to it are ignored.
- R5: Slot i (1..NUM_SLOTS) in mode 1 matches when addr[i-1] <= byteAddr>>2 < addr[i]. Mode 0 never matches, and modes 2 and 3 never match either. Slot 0 never grants anything.
- R6: When several slots match, the lowest-indexed one alone decides.
- R7: In the deciding slot, permission bit 2*WID grants reads and bit 2*WID+1 grants writes.
- R8: A WID of 32 or higher is always denied.
- R9: A request that matches no slot is denied. This includes every address at or above REGION_TOP.
- R10: respValid and respAllow are registered and appear exactly one cycle after the request.
- R11: On a denial with the error-cause valid bit (bit 63) clear, the block records the error. The cause becomes bit 63 set, bit 8 set for a write, and the WID in bits 5:0. The error-address register takes the byte address. While bit 63 is set, later denials leave both registers unchanged.
- R12: Both error registers accept writes. Writing zero to the cause register clears bit 63 and re-arms capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | REG_AW | Register byte offset |
| regWdata | input | 64 | Register write data |
| regRdata | output | 64 | Register read data (combinational) |
| reqValid | input | 1 | Access request present |
| reqAddr | input | ADDR_W | Byte address of the request |
| reqWid | input | WID_W | World ID of the requester |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| respValid | output | 1 | Decision valid, one cycle after the request |
| respAllow | output | 1 | 1 when the request is granted |

## Verification
Some properties are checked on every cycle: response timing, the denial of out-of-range world IDs, the hold of a pending error record, its release by a zero write, and the rule that a new record only follows a denied request. Region decoding, lowest-slot priority and read/write bit selection depend on the table contents, so only the bench's scenarios can show them. The bench covers them with directed slot layouts (boundaries, overlapping spans, disabled slots) and with random tables checked against a reference model. Granule masking and the fixed top bound are also shown through register readback in those scenarios.

// File: rtl/wgc_pkg.sv
package wgc_pkg;

  localparam logic [1:0] CFG_OFF = 2'd0;
  localparam logic [1:0] CFG_TOR = 2'd1;

  localparam int ERR_VALID_BIT = 63;
  localparam int ERR_WRITE_BIT = 8;

  localparam int OFS_COUNT  = 'h008;
  localparam int OFS_CAUSE  = 'h010;
  localparam int OFS_EADDR  = 'h018;
  localparam int OFS_SLOTS  = 'h020;
  localparam int SLOT_SHIFT = 5;

  typedef struct packed {
    logic addrWe;
    logic permWe;
    logic cfgWe;
    logic causeWe;
    logic eaddrWe;
    logic capture;
  } wgc_strobe_t;

  typedef enum logic [2:0] {
    RD_NONE, RD_COUNT, RD_CAUSE, RD_EADDR, RD_SADDR, RD_PERM, RD_CFG
  } wgc_rdsel_e;

endpackage

// File: rtl/wgc_ctrl.sv
module wgc_ctrl
  import wgc_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int REG_AW    = 12,
  parameter int IDX_W     = $clog2(NUM_SLOTS + 1)
) (
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              reqValid,
  input  logic              reqDenied,
  input  logic              errPending,
  output wgc_strobe_t       strobe,
  output logic [IDX_W-1:0]  slotSel,
  output wgc_rdsel_e        rdSel
);

  localparam int SW = REG_AW - SLOT_SHIFT;

  logic [REG_AW-1:0] relAddr;
  logic [SW-1:0]     slotWide;
  logic              inArray;

  assign relAddr  = regAddr - REG_AW'(OFS_SLOTS);
  assign slotWide = relAddr[REG_AW-1:SLOT_SHIFT];
  assign inArray  = (regAddr >= REG_AW'(OFS_SLOTS)) && (slotWide <= SW'(NUM_SLOTS));

  always_comb begin
    rdSel   = RD_NONE;
    slotSel = IDX_W'(slotWide);
    if (regAddr == REG_AW'(OFS_COUNT))      rdSel = RD_COUNT;
    else if (regAddr == REG_AW'(OFS_CAUSE)) rdSel = RD_CAUSE;
    else if (regAddr == REG_AW'(OFS_EADDR)) rdSel = RD_EADDR;
    else if (inArray) begin
      case (relAddr[SLOT_SHIFT-1:0])
        5'h00:   rdSel = RD_SADDR;
        5'h08:   rdSel = RD_PERM;
        5'h10:   rdSel = RD_CFG;
        default: rdSel = RD_NONE;
      endcase
    end
  end

  always_comb begin
    strobe.addrWe  = regWe && (rdSel == RD_SADDR) && (slotSel != IDX_W'(NUM_SLOTS));
    strobe.permWe  = regWe && (rdSel == RD_PERM);
    strobe.cfgWe   = regWe && (rdSel == RD_CFG);
    strobe.causeWe = regWe && (rdSel == RD_CAUSE);
    strobe.eaddrWe = regWe && (rdSel == RD_EADDR);
    strobe.capture = reqValid && reqDenied && !errPending
                     && !(strobe.causeWe || strobe.eaddrWe);
  end

endmodule

// File: rtl/wgc_datapath.sv
module wgc_datapath
  import wgc_pkg::*;
#(
  parameter int          NUM_SLOTS   = 4,
  parameter int          ADDR_W      = 32,
  parameter int          WID_W       = 6,
  parameter logic [63:0] REGION_TOP  = 64'h0010_0000,
  parameter int          TRUSTED_WID = 3,
  parameter int          GRAN_BITS   = 12,
  parameter int          IDX_W       = $clog2(NUM_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  wgc_strobe_t       strobe,
  input  logic [IDX_W-1:0]  slotSel,
  input  wgc_rdsel_e        rdSel,
  input  logic [63:0]       regWdata,
  output logic [63:0]       regRdata,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WID_W-1:0]  reqWid,
  input  logic              reqWrite,
  output logic              reqDenied,
  output logic              errPending,
  output logic              respValid,
  output logic              respAllow
);

  localparam int              WA_W       = ADDR_W - 2;
  localparam int              LOW_Z      = GRAN_BITS - 2;
  localparam logic [WA_W-1:0] GMASK      = ~WA_W'((64'd1 << LOW_Z) - 64'd1);
  localparam logic [WA_W-1:0] TOP_WORD   = WA_W'(REGION_TOP >> 2);
  localparam logic [63:0]     TRUST_PERM = 64'd3 << (2 * TRUSTED_WID);

  logic [WA_W-1:0]   slotAddr [NUM_SLOTS];
  logic [63:0]       slotPerm [NUM_SLOTS+1];
  logic [1:0]        slotCfg  [NUM_SLOTS+1];
  logic [WA_W-1:0]   bound    [NUM_SLOTS+1];
  logic [NUM_SLOTS:0] hit;
  logic [63:0]       errCauseQ;
  logic [ADDR_W-1:0] errAddrQ;
  logic [WA_W-1:0]   reqWord;
  logic [IDX_W-1:0]  selIdx;
  logic              anyHit, widOk, allowComb;
  logic [63:0]       permSel;

  assign reqWord = reqAddr[ADDR_W-1:2];

  // Lower/upper bounds: writable slots, then the fixed region top.
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_bound
    assign bound[g] = slotAddr[g];
  end
  assign bound[NUM_SLOTS] = TOP_WORD;

  // Slot 0 is only a lower bound.
  assign hit[0] = 1'b0;
  for (genvar g = 1; g <= NUM_SLOTS; g++) begin : g_match
    assign hit[g] = (slotCfg[g] == CFG_TOR) && (bound[g-1] <= reqWord) && (reqWord < bound[g]);
  end

  always_comb begin
    anyHit = 1'b0;
    selIdx = '0;
    for (int i = NUM_SLOTS; i >= 1; i--) begin
      if (hit[i]) begin
        anyHit = 1'b1;
        selIdx = IDX_W'(i);
      end
    end
  end

  assign permSel   = slotPerm[selIdx];
  assign widOk     = 32'(reqWid) < 32'd32;
  assign allowComb = anyHit && widOk && permSel[{reqWid[4:0], reqWrite}];
  assign reqDenied = !allowComb;
  assign errPending = errCauseQ[ERR_VALID_BIT];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SLOTS; i++) slotAddr[i] <= '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
        slotPerm[i] <= '0;
        slotCfg[i]  <= CFG_OFF;
      end
      slotPerm[NUM_SLOTS] <= TRUST_PERM;
      slotCfg[NUM_SLOTS]  <= CFG_TOR;
      errCauseQ <= '0;
      errAddrQ  <= '0;
      respValid <= 1'b0;
      respAllow <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++)
        if (strobe.addrWe && slotSel == IDX_W'(i))
          slotAddr[i] <= regWdata[WA_W-1:0] & GMASK;
      for (int i = 0; i <= NUM_SLOTS; i++) begin
        if (strobe.permWe && slotSel == IDX_W'(i)) slotPerm[i] <= regWdata;
        if (strobe.cfgWe && slotSel == IDX_W'(i))  slotCfg[i]  <= regWdata[1:0];
      end
      if (strobe.causeWe) errCauseQ <= regWdata;
      else if (strobe.capture)
        errCauseQ <= (64'd1 << ERR_VALID_BIT) | (64'(reqWrite) << ERR_WRITE_BIT) | 64'(reqWid);
      if (strobe.eaddrWe) errAddrQ <= regWdata[ADDR_W-1:0];
      else if (strobe.capture) errAddrQ <= reqAddr;
      respValid <= reqValid;
      respAllow <= reqValid && allowComb;
    end
  end

  always_comb begin
    case (rdSel)
      RD_COUNT: regRdata = 64'(NUM_SLOTS);
      RD_CAUSE: regRdata = errCauseQ;
      RD_EADDR: regRdata = 64'(errAddrQ);
      RD_SADDR: regRdata = 64'(bound[slotSel]);
      RD_PERM:  regRdata = slotPerm[slotSel];
      RD_CFG:   regRdata = 64'(slotCfg[slotSel]);
      default:  regRdata = '0;
    endcase
  end

endmodule

// File: rtl/wid_slot_checker.sv
module wid_slot_checker
  import wgc_pkg::*;
#(
  parameter int          NUM_SLOTS   = 4,
  parameter int          ADDR_W      = 32,
  parameter int          WID_W       = 6,
  parameter int          REG_AW      = 12,
  parameter logic [63:0] REGION_TOP  = 64'h0010_0000,
  parameter int          TRUSTED_WID = 3,
  parameter int          GRAN_BITS   = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [63:0]       regWdata,
  output logic [63:0]       regRdata,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WID_W-1:0]  reqWid,
  input  logic              reqWrite,
  output logic              respValid,
  output logic              respAllow
);

  localparam int IDX_W = $clog2(NUM_SLOTS + 1);

  wgc_strobe_t      strobe;
  wgc_rdsel_e       rdSel;
  logic [IDX_W-1:0] slotSel;
  logic             reqDenied;
  logic             errPending;

  wgc_ctrl #(
    .NUM_SLOTS(NUM_SLOTS), .REG_AW(REG_AW), .IDX_W(IDX_W)
  ) u_ctrl (
    .regWe(regWe), .regAddr(regAddr), .reqValid(reqValid),
    .reqDenied(reqDenied), .errPending(errPending),
    .strobe(strobe), .slotSel(slotSel), .rdSel(rdSel)
  );

  wgc_datapath #(
    .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .WID_W(WID_W),
    .REGION_TOP(REGION_TOP), .TRUSTED_WID(TRUSTED_WID),
    .GRAN_BITS(GRAN_BITS), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .slotSel(slotSel), .rdSel(rdSel),
    .regWdata(regWdata), .regRdata(regRdata),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqWid(reqWid), .reqWrite(reqWrite),
    .reqDenied(reqDenied), .errPending(errPending),
    .respValid(respValid), .respAllow(respAllow)
  );

endmodule

// File: rtl/wid_slot_checker_sva.sv
module wid_slot_checker_sva #(
  parameter int WID_W  = 6,
  parameter int REG_AW = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [REG_AW-1:0] regAddr,
  input logic [63:0]       regWdata,
  input logic              reqValid,
  input logic [WID_W-1:0]  reqWid,
  input logic              respValid,
  input logic              respAllow,
  input logic              errPending
);

  logic causeWrite;
  assign causeWrite = regWe && (regAddr == REG_AW'('h010));

  a_r10_resp_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);

  a_r10_no_spurious_resp: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!respValid && !respAllow));

  a_r8_high_wid_denied: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (32'(reqWid) >= 32'd32)) |=> !respAllow);

  a_r12_zero_clears: assert property (@(posedge clk) disable iff (!rstN)
    (causeWrite && regWdata == 64'd0) |=> !errPending);

  a_r11_record_held: assert property (@(posedge clk) disable iff (!rstN)
    (errPending && !causeWrite) |=> errPending);

  a_r11_record_from_denial: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(errPending) && !$past(regWe)) |-> ($past(reqValid) && respValid && !respAllow));

endmodule

bind wid_slot_checker wid_slot_checker_sva #(
  .WID_W(WID_W), .REG_AW(REG_AW)
) u_sva (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
  .reqValid(reqValid), .reqWid(reqWid), .respValid(respValid),
  .respAllow(respAllow), .errPending(errPending)
);

// File: tb/wid_slot_checker_tb.sv
module wid_slot_checker_tb;

  localparam int          N     = 4;
  localparam logic [63:0] TOP   = 64'h0010_0000;
  localparam int          TW    = 3;
  localparam logic [29:0] GMASK = ~30'h3FF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [11:0] regAddr = '0;
  logic [63:0] regWdata = '0;
  logic [63:0] regRdata;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [5:0]  reqWid = '0;
  logic        reqWrite = 1'b0;
  logic        respValid, respAllow;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  logic [29:0] mAddr [0:N];
  logic [63:0] mPerm [0:N];
  logic [1:0]  mCfg  [0:N];
  logic [63:0] mCause;
  logic [31:0] mEaddr;

  always #4 clk = ~clk;

  wid_slot_checker u_dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .reqValid(reqValid), .reqAddr(reqAddr), .reqWid(reqWid),
    .reqWrite(reqWrite), .respValid(respValid), .respAllow(respAllow)
  );

  function automatic logic expAllow(input logic [31:0] a, input int wid, input logic wr);
    logic [29:0] w = a[31:2];
    if (wid >= 32) return 1'b0;
    for (int i = 1; i <= N; i++)
      if (mCfg[i] == 2'd1 && mAddr[i-1] <= w && w < mAddr[i])
        return mPerm[i][2*wid + int'(wr)];
    return 1'b0;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input int ofs, input logic [63:0] d);
    @(negedge clk);
    regAddr = 12'(ofs); regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input int ofs, output logic [63:0] d);
    @(negedge clk);
    regAddr = 12'(ofs);
    #1 d = regRdata;
  endtask

  task automatic setAddr(input int i, input logic [63:0] v);
    regWrite('h20 + 'h20*i, v);
    if (i < N) mAddr[i] = v[29:0] & GMASK;
  endtask
  task automatic setPerm(input int i, input logic [63:0] v);
    regWrite('h28 + 'h20*i, v); mPerm[i] = v;
  endtask
  task automatic setCfg(input int i, input logic [1:0] v);
    regWrite('h30 + 'h20*i, 64'(v)); mCfg[i] = v;
  endtask
  task automatic clearErr();
    regWrite('h10, 64'd0); mCause = '0;
  endtask

  task automatic doReq(input string tag, input logic [31:0] a, input int wid,
                       input logic wr, input logic exp);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqWid = 6'(wid); reqWrite = wr;
    @(negedge clk);
    reqValid = 1'b0;
    chk({tag, " R10 respValid"}, 64'(respValid), 64'd1);
    chk(tag, 64'(respAllow), 64'(exp));
    if (!exp && !mCause[63]) begin
      mCause = (64'd1 << 63) | (64'(wr) << 8) | 64'(wid);
      mEaddr = a;
    end
  endtask

  task automatic chkErr(input string tag);
    logic [63:0] d;
    regRead('h10, d); chk({tag, " R11 cause"}, d, mCause);
    regRead('h18, d); chk({tag, " R11 eaddr"}, d, 64'(mEaddr));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 190000);
    nChecks++; nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [63:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin mAddr[i] = '0; mPerm[i] = '0; mCfg[i] = 2'd0; end
    mAddr[N] = TOP[31:2]; mPerm[N] = 64'd3 << (2*TW); mCfg[N] = 2'd1;
    mCause = '0; mEaddr = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state, R2 offsets
    regRead('h08, d); chk("R1 count", d, 64'd4);
    regRead('h20, d); chk("R1 slot0 addr", d, 64'd0);
    regRead('h48, d); chk("R1 slot1 perm", d, 64'd0);
    regRead('h50, d); chk("R1 slot1 cfg", d, 64'd0);
    regRead('hB0, d); chk("R1 top cfg", d, 64'd1);
    regRead('hA8, d); chk("R1 top perm", d, 64'h0000_0000_0000_00C0);
    regRead('h10, d); chk("R1 cause", d, 64'd0);
    doReq("R1 trusted read", 32'h0000_1000, TW, 1'b0, 1'b1);
    doReq("R1 trusted write", 32'h000F_FFFC, TW, 1'b1, 1'b1);
    doReq("R1 other denied", 32'h0000_1000, 1, 1'b0, 1'b0);
    chk("R11 first cause", mCause, 64'h8000_0000_0000_0001);
    chkErr("R11 first");
    doReq("R11 second denial", 32'h0000_2000, 5, 1'b1, 1'b0);
    chkErr("R11 held");
    clearErr(); chkErr("R12 cleared");
    doReq("R12 rearmed", 32'h0000_2000, 5, 1'b1, 1'b0);
    chk("R12 new cause", mCause, 64'h8000_0000_0000_0105);
    chkErr("R12 rearm");
    clearErr();

    // R3 granule masking, R4 fixed top
    regWrite('h40, 64'h1234);
    regRead('h40, d); chk("R3 granule mask", d, 64'h1000);
    regWrite('h40, 64'h0);
    regWrite('hA0, 64'h55);
    regRead('hA0, d); chk("R4 top addr fixed", d, 64'h0004_0000);

    // R5/R7 directed layout
    setAddr(0, 64'h1000); setCfg(0, 2'd1); setPerm(0, '1);
    setAddr(1, 64'h2000); setCfg(1, 2'd1); setPerm(1, 64'h10);
    setAddr(2, 64'h3000); setCfg(2, 2'd0); setPerm(2, '1);
    setAddr(3, 64'h4000); setCfg(3, 2'd1); setPerm(3, 64'h20);
    doReq("R5 low bound inclusive", 32'h0000_4000, 2, 1'b0, 1'b1);
    doReq("R5 top bound-4", 32'h0000_7FFC, 2, 1'b0, 1'b1);
    doReq("R7 write bit clear", 32'h0000_4000, 2, 1'b1, 1'b0);
    doReq("R5 OFF slot no match", 32'h0000_8000, 2, 1'b0, 1'b0);
    doReq("R7 write granted", 32'h0000_C000, 2, 1'b1, 1'b1);
    doReq("R7 read not granted", 32'h0000_C000, 2, 1'b0, 1'b0);
    doReq("R5 slot0 never grants", 32'h0000_0000, 2, 1'b0, 1'b0);
    doReq("R5 top slot trusted", 32'h0001_0000, TW, 1'b1, 1'b1);
    clearErr();

    // R6 overlap: slot3 emptied, top slot spans whole region
    setAddr(3, 64'h0);
    doReq("R6 lowest slot decides", 32'h0000_4000, TW, 1'b0, 1'b0);
    doReq("R6 falls to top slot", 32'h0000_8000, TW, 1'b0, 1'b1);

    // R8/R9
    setPerm(N, '1);
    doReq("R8 wid31 allowed", 32'h0000_8000, 31, 1'b1, 1'b1);
    doReq("R8 wid32 denied", 32'h0000_8000, 32, 1'b0, 1'b0);
    doReq("R8 wid40 denied", 32'h0000_8000, 40, 1'b1, 1'b0);
    doReq("R9 beyond region", 32'h0010_0000, TW, 1'b0, 1'b0);
    setCfg(N, 2'd3);
    doReq("R9 mode3 no match", 32'h0000_8000, TW, 1'b0, 1'b0);
    chkErr("R11 directed");
    clearErr();

    // Random tables checked against the model (R5, R6, R7, R11)
    for (int it = 0; it < 300; it++) begin
      if (it % 25 == 0) begin
        for (int i = 0; i <= N; i++) begin
          setAddr(i, 64'($urandom_range(0, 63)) << 10);
          setPerm(i, {$urandom, $urandom});
          setCfg(i, 2'($urandom_range(0, 3)));
        end
      end
      begin
        logic [31:0] a = 32'($urandom_range(0, 'h47FFF));
        int w = int'($urandom_range(0, 40));
        logic wr = 1'($urandom);
        doReq("R7 random", a, w, wr, expAllow(a, w, wr));
      end
      if (it % 5 == 0) chkErr("R11 random");
      if (it % 7 == 0) clearErr();
    end

    finishRun();
  end

endmodule